// File: doc/BRIEF.md
# Relocatable Address Window Decoder

This block sits behind a microcontroller bus that carries the low address byte and data on shared lines, with the upper address byte on separate pins. While the address strobe is high, the block captures the full 16-bit address at the clock edge. It then compares the captured upper bits against two configuration bytes. One byte places a 1K-byte register window and the other places an 8K-byte memory window, so each window sits on its own boundary within the 64K map. A chip enable gates both selects. When both windows claim the same address, the register window wins.

The memory-map byte has two more jobs. One bit picks the polarity of an external reset pin, and the block reports the resulting reset request with active-high sense. Another bit switches Port B between two modes. In the first, Port B passes general-purpose output data and direction through. In the second, Port B drives the captured low address byte with all output enables on. An unlock sequencer outside this block loads the configuration bytes through a simple write port. The bytes are held in flops that return to their defaults on reset.

Top module: `amap_decode_top`

## Requirements
- R1: After synchronous reset, the register-map byte reads 0x81, the memory-map byte reads 0x07 and the captured address is 0x0000.
- R2: On a clock edge with `as_i` high, the captured address becomes {`ahi_i`, `ad_i`}. With `as_i` low, it is unchanged.
- R3: `reg_sel_o` is 1 exactly when `ce_i` is 1 and captured address bits 15:10 equal register-map bits 5:0.
- R4: `mem_sel_o` is 1 when `ce_i` is 1, captured address bits 15:13 equal memory-map bits 2:0, and the register window does not match.
- R5: If one address matches both windows, `reg_sel_o` is 1 and `mem_sel_o` is 0.
- R6: With `ce_i` low, both `reg_sel_o` and `mem_sel_o` are 0, whatever the address.
- R7: A write to the register-map byte stores data bits 5:0. Bits 7:6 always read 2'b10, and a written value there has no effect.
- R8: A write to the memory-map byte stores data bits 5, 3 and 2:0. Bits 7:6 and 4 always read 0.
- R9: `rst_req_o` equals `rst_pin_i` when memory-map bit 3 is 1 (active-high pin). It equals the inverse of `rst_pin_i` when that bit is 0 (active-low pin).
- R10: When memory-map bit 5 is 0, `pb_o` = `pb_gpio_i` and `pb_oe_o` = `pb_dir_i`. When it is 1, `pb_o` = captured address bits 7:0 and `pb_oe_o` = 0xFF.
- R11: `cfg_wr_i` high at a clock edge loads the register-map byte when `cfg_sel_i` = 0 and the memory-map byte when `cfg_sel_i` = 1. The new value is visible after that edge. Without a write, both bytes hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| as_i | input | 1 | Address strobe, capture enable |
| ad_i | input | 8 | Multiplexed low address / data byte |
| ahi_i | input | 8 | Upper address bits 15:8 |
| ce_i | input | 1 | Chip enable, active high |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 = register-map byte, 1 = memory-map byte |
| cfg_wdata_i | input | 8 | Configuration write data |
| rst_pin_i | input | 1 | External reset pin, polarity set by configuration |
| pb_gpio_i | input | 8 | Port B general-purpose output data |
| pb_dir_i | input | 8 | Port B general-purpose output enables |
| reg_sel_o | output | 1 | Register window select |
| mem_sel_o | output | 1 | Memory window select |
| rst_req_o | output | 1 | Reset request, active high |
| pb_o | output | 8 | Port B output data |
| pb_oe_o | output | 8 | Port B output enables |
| regmap_o | output | 8 | Current register-map byte |
| memmap_o | output | 8 | Current memory-map byte |

## Verification
The bench moves the register window inside the memory window and strobes an address that falls in both. A decoder without priority would raise both selects there. It writes 2'b01 and 2'b11 into the register-map top bits and ones into the memory-map reserved bits, and a design that keeps those bits shows them on the readback ports. It changes `ad_i` with the strobe low while Port B is in address mode, so a latch that is transparent or always enabled changes `pb_o`. It drives the reset pin at both polarity settings, which catches an inverted polarity sense. It also drops the chip enable on a matching address, which exposes a select that ignores the enable.

// File: rtl/amap_pkg.sv
package amap_pkg;

    localparam int CFG_W = 8;

    localparam logic [CFG_W-1:0] REGMAP_RST = 8'h81;
    localparam logic [CFG_W-1:0] MEMMAP_RST = 8'h07;

    // register-map byte: fixed pattern in the top two bits
    localparam logic [1:0] REGMAP_TOP_FIXED = 2'b10;
    localparam logic [CFG_W-1:0] REGMAP_KEEP = 8'h3F;

    // memory-map byte: writable bits 5, 3, 2:0
    localparam logic [CFG_W-1:0] MEMMAP_KEEP = 8'h2F;
    localparam int MM_POL_BIT = 3;
    localparam int MM_LAM_BIT = 5;

    typedef enum logic {
        TGT_REGMAP = 1'b0,
        TGT_MEMMAP = 1'b1
    } cfg_tgt_e;

    typedef struct packed {
        logic [CFG_W-1:0] regmap;
        logic [CFG_W-1:0] memmap;
    } cfg_view_t;

    typedef struct packed {
        logic lam;
        logic pol_high;
    } mode_t;

    typedef struct packed {
        logic reg_hit;
        logic mem_hit;
    } win_hit_t;

    function automatic logic [CFG_W-1:0] clean_regmap(input logic [CFG_W-1:0] d);
        return {REGMAP_TOP_FIXED, 6'b0} | (d & REGMAP_KEEP);
    endfunction

    function automatic logic [CFG_W-1:0] clean_memmap(input logic [CFG_W-1:0] d);
        return d & MEMMAP_KEEP;
    endfunction

    function automatic mode_t mode_of(input logic [CFG_W-1:0] mm);
        mode_t m;
        m.lam      = mm[MM_LAM_BIT];
        m.pol_high = mm[MM_POL_BIT];
        return m;
    endfunction

endpackage

// File: rtl/amap_cfg_regs.sv
module amap_cfg_regs
    import amap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic             tgt_i,
    input  logic [CFG_W-1:0] wdata_i,
    output cfg_view_t        cfg_o
);

    logic [CFG_W-1:0] regmap_q;
    logic [CFG_W-1:0] memmap_q;
    cfg_tgt_e         tgt;

    assign tgt = cfg_tgt_e'(tgt_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            regmap_q <= REGMAP_RST;
            memmap_q <= MEMMAP_RST;
        end else if (wr_i) begin
            case (tgt)
                TGT_REGMAP: regmap_q <= clean_regmap(wdata_i);
                TGT_MEMMAP: memmap_q <= clean_memmap(wdata_i);
                default: ;
            endcase
        end
    end

    assign cfg_o.regmap = regmap_q;
    assign cfg_o.memmap = memmap_q;

    // R11 / R7: register-map write keeps low six bits of data
    p_regmap_load_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !tgt_i) |=> (regmap_q[5:0] == $past(wdata_i[5:0])));

    // R7: fixed top bits survive any write
    p_regmap_top_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !tgt_i) |=> (regmap_q[7:6] == 2'b10));

    // R8: memory-map write masks reserved bits
    p_memmap_load_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_i && tgt_i) |=> (memmap_q == ($past(wdata_i) & 8'h2F)));

    // R11: no write, no change
    p_cfg_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> ($stable(regmap_q) && $stable(memmap_q)));

endmodule

// File: rtl/amap_addr_latch.sv
module amap_addr_latch #(
    parameter int ADDR_W = 16,
    parameter int LO_W   = 8,
    localparam int HI_W  = ADDR_W - LO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              as_i,
    input  logic [LO_W-1:0]   lo_i,
    input  logic [HI_W-1:0]   hi_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (as_i) begin
            addr_q <= {hi_i, lo_i};
        end
    end

    assign addr_o = addr_q;

    // R2: capture on strobe
    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        as_i |=> (addr_o == $past({hi_i, lo_i})));

    // R2: hold without strobe
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !as_i |=> $stable(addr_o));

endmodule

// File: rtl/amap_window_dec.sv
module amap_window_dec
    import amap_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int REG_WIN_AW = 10,
    parameter int MEM_WIN_AW = 13,
    localparam int REG_TAG_W = ADDR_W - REG_WIN_AW,
    localparam int MEM_TAG_W = ADDR_W - MEM_WIN_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ce_i,
    input  cfg_view_t         cfg_i,
    output logic              reg_sel_o,
    output logic              mem_sel_o
);

    win_hit_t hit;

    always_comb begin
        hit.reg_hit = (addr_i[ADDR_W-1 -: REG_TAG_W] == cfg_i.regmap[REG_TAG_W-1:0]);
        hit.mem_hit = (addr_i[ADDR_W-1 -: MEM_TAG_W] == cfg_i.memmap[MEM_TAG_W-1:0]);
    end

    always_comb begin
        reg_sel_o = 1'b0;
        mem_sel_o = 1'b0;
        if (ce_i) begin
            if (hit.reg_hit) begin
                reg_sel_o = 1'b1;
            end else if (hit.mem_hit) begin
                mem_sel_o = 1'b1;
            end
        end
    end

    // R5: never both selects together
    p_one_sel_r5: assert property (@(posedge clk) disable iff (rst)
        !(reg_sel_o && mem_sel_o));

    // R6: chip enable gates both selects
    p_ce_gate_r6: assert property (@(posedge clk) disable iff (rst)
        !ce_i |-> (!reg_sel_o && !mem_sel_o));

endmodule

// File: rtl/amap_portb_mux.sv
module amap_portb_mux
    import amap_pkg::*;
#(
    parameter int PB_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  mode_t           mode_i,
    input  logic [PB_W-1:0] addr_lo_i,
    input  logic [PB_W-1:0] gpio_i,
    input  logic [PB_W-1:0] dir_i,
    output logic [PB_W-1:0] pb_o,
    output logic [PB_W-1:0] pb_oe_o
);

    for (genvar b = 0; b < PB_W; b++) begin : g_bit
        assign pb_o[b]    = mode_i.lam ? addr_lo_i[b] : gpio_i[b];
        assign pb_oe_o[b] = mode_i.lam | dir_i[b];
    end

    // R10: address mode drives every pin
    p_lam_drive_r10: assert property (@(posedge clk) disable iff (rst)
        mode_i.lam |-> (pb_oe_o == {PB_W{1'b1}}));

endmodule

// File: rtl/amap_decode_top.sv
module amap_decode_top
    import amap_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BYTE_W     = 8,
    parameter int REG_WIN_AW = 10,
    parameter int MEM_WIN_AW = 13,
    localparam int HI_W      = ADDR_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              as_i,
    input  logic [BYTE_W-1:0] ad_i,
    input  logic [HI_W-1:0]   ahi_i,
    input  logic              ce_i,
    input  logic              cfg_wr_i,
    input  logic              cfg_sel_i,
    input  logic [BYTE_W-1:0] cfg_wdata_i,
    input  logic              rst_pin_i,
    input  logic [BYTE_W-1:0] pb_gpio_i,
    input  logic [BYTE_W-1:0] pb_dir_i,
    output logic              reg_sel_o,
    output logic              mem_sel_o,
    output logic              rst_req_o,
    output logic [BYTE_W-1:0] pb_o,
    output logic [BYTE_W-1:0] pb_oe_o,
    output logic [BYTE_W-1:0] regmap_o,
    output logic [BYTE_W-1:0] memmap_o
);

    cfg_view_t         cfg;
    mode_t             mode;
    logic [ADDR_W-1:0] addr_q;

    amap_cfg_regs u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (cfg_wr_i),
        .tgt_i   (cfg_sel_i),
        .wdata_i (cfg_wdata_i),
        .cfg_o   (cfg)
    );

    amap_addr_latch #(
        .ADDR_W (ADDR_W),
        .LO_W   (BYTE_W)
    ) u_latch (
        .clk    (clk),
        .rst    (rst),
        .as_i   (as_i),
        .lo_i   (ad_i),
        .hi_i   (ahi_i),
        .addr_o (addr_q)
    );

    amap_window_dec #(
        .ADDR_W     (ADDR_W),
        .REG_WIN_AW (REG_WIN_AW),
        .MEM_WIN_AW (MEM_WIN_AW)
    ) u_dec (
        .clk       (clk),
        .rst       (rst),
        .addr_i    (addr_q),
        .ce_i      (ce_i),
        .cfg_i     (cfg),
        .reg_sel_o (reg_sel_o),
        .mem_sel_o (mem_sel_o)
    );

    assign mode = mode_of(cfg.memmap);

    amap_portb_mux #(
        .PB_W (BYTE_W)
    ) u_pb (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (mode),
        .addr_lo_i (addr_q[BYTE_W-1:0]),
        .gpio_i    (pb_gpio_i),
        .dir_i     (pb_dir_i),
        .pb_o      (pb_o),
        .pb_oe_o   (pb_oe_o)
    );

    assign rst_req_o = mode.pol_high ? rst_pin_i : ~rst_pin_i;
    assign regmap_o  = cfg.regmap;
    assign memmap_o  = cfg.memmap;

    // R9: reset request follows the pin in active-high mode
    p_pol_high_r9: assert property (@(posedge clk) disable iff (rst)
        memmap_o[3] |-> (rst_req_o == rst_pin_i));

    // R9: reset request inverts the pin in active-low mode
    p_pol_low_r9: assert property (@(posedge clk) disable iff (rst)
        !memmap_o[3] |-> (rst_req_o != rst_pin_i));

endmodule

// File: tb/amap_decode_top_bench.sv
module amap_decode_top_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       as_i = 1'b0;
    logic [7:0] ad_i = '0;
    logic [7:0] ahi_i = '0;
    logic       ce_i = 1'b0;
    logic       cfg_wr_i = 1'b0;
    logic       cfg_sel_i = 1'b0;
    logic [7:0] cfg_wdata_i = '0;
    logic       rst_pin_i = 1'b0;
    logic [7:0] pb_gpio_i = '0;
    logic [7:0] pb_dir_i = '0;
    logic       reg_sel_o, mem_sel_o, rst_req_o;
    logic [7:0] pb_o, pb_oe_o, regmap_o, memmap_o;

    int checks = 0;
    int errors = 0;

    int m_regmap = 0;
    int m_memmap = 0;
    int m_addr   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    amap_decode_top u_amap_decode_top (
        .clk         (clk),
        .rst         (rst),
        .as_i        (as_i),
        .ad_i        (ad_i),
        .ahi_i       (ahi_i),
        .ce_i        (ce_i),
        .cfg_wr_i    (cfg_wr_i),
        .cfg_sel_i   (cfg_sel_i),
        .cfg_wdata_i (cfg_wdata_i),
        .rst_pin_i   (rst_pin_i),
        .pb_gpio_i   (pb_gpio_i),
        .pb_dir_i    (pb_dir_i),
        .reg_sel_o   (reg_sel_o),
        .mem_sel_o   (mem_sel_o),
        .rst_req_o   (rst_req_o),
        .pb_o        (pb_o),
        .pb_oe_o     (pb_oe_o),
        .regmap_o    (regmap_o),
        .memmap_o    (memmap_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model update for one clock edge
    task automatic model_edge();
        if (rst) begin
            m_regmap = 'h81;
            m_memmap = 'h07;
            m_addr   = 0;
        end else begin
            if (as_i) m_addr = {ahi_i, ad_i};
            if (cfg_wr_i) begin
                if (cfg_sel_i) m_memmap = cfg_wdata_i & 'h2F;
                else           m_regmap = (cfg_wdata_i & 'h3F) | 'h80;
            end
        end
    endtask

    task automatic compare_all();
        bit reg_hit, mem_hit, lam;
        int e_pb, e_oe, e_rst;
        reg_hit = ((m_addr >> 10) & 'h3F) == (m_regmap & 'h3F);
        mem_hit = ((m_addr >> 13) & 'h7) == (m_memmap & 'h7);
        lam     = (m_memmap >> 5) & 1;
        e_pb    = lam ? (m_addr & 'hFF) : pb_gpio_i;
        e_oe    = lam ? 'hFF : pb_dir_i;
        e_rst   = ((m_memmap >> 3) & 1) ? rst_pin_i : !rst_pin_i;
        check("R3 R6 reg_sel", reg_sel_o, ce_i && reg_hit);
        check("R4 R5 R6 mem_sel", mem_sel_o, ce_i && mem_hit && !reg_hit);
        check("R9 rst_req", rst_req_o, e_rst);
        check("R10 R2 pb_o", pb_o, e_pb);
        check("R10 pb_oe", pb_oe_o, e_oe);
        check("R1 R7 R11 regmap", regmap_o, m_regmap);
        check("R1 R8 R11 memmap", memmap_o, m_memmap);
    endtask

    // inputs are set after a negedge; one call covers one edge
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic strobe(input int a, input bit ce);
        as_i = 1'b1; ahi_i = a[15:8]; ad_i = a[7:0]; ce_i = ce;
        tick();
        as_i = 1'b0;
        tick();
    endtask

    task automatic cfg_write(input bit sel, input int d);
        cfg_wr_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d[7:0];
        tick();
        cfg_wr_i = 1'b0;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;
        // R1: defaults after reset
        check("R1 regmap reset", regmap_o, 'h81);
        check("R1 memmap reset", memmap_o, 'h07);
        tick();

        // R3: default register window 0x0400
        strobe('h0412, 1'b1);
        check("R3 default reg window", reg_sel_o, 1);
        // R4: default memory window 0xE000
        strobe('hE055, 1'b1);
        check("R4 default mem window", mem_sel_o, 1);
        strobe('h3000, 1'b1);
        // R6: matching address with chip enable low
        strobe('h0400, 1'b0);
        check("R6 ce low", reg_sel_o, 0);

        // R9: default active-low reset pin
        rst_pin_i = 1'b0; tick();
        check("R9 active low", rst_req_o, 1);
        rst_pin_i = 1'b1; tick();

        // R7: top bits written as 01 are ignored
        cfg_write(1'b0, 'h42);
        check("R7 top bits forced", regmap_o, 'h82);
        // R8: reserved bits written as ones read zero
        cfg_write(1'b1, 'hF8);
        check("R8 reserved bits", memmap_o, 'h28);
        // R9: now active high
        rst_pin_i = 1'b1; tick();
        check("R9 active high", rst_req_o, 1);

        // R5: 0x0800 sits in both windows
        ce_i = 1'b1;
        strobe('h0855, 1'b1);
        check("R5 priority mem_sel", mem_sel_o, 0);
        check("R5 priority reg_sel", reg_sel_o, 1);
        strobe('h1234, 1'b1);
        check("R4 relocated mem window", mem_sel_o, 1);

        // R10 R2: address mode, data phase must not disturb the latch
        ad_i = 'hA5; as_i = 1'b0; tick();
        check("R2 latch holds", pb_o, 'h34);
        check("R10 lam oe", pb_oe_o, 'hFF);

        // R10: back to general-purpose mode
        cfg_write(1'b1, 'h07);
        pb_gpio_i = 'h3C; pb_dir_i = 'h0F; tick();
        check("R10 gpio data", pb_o, 'h3C);
        check("R10 gpio oe", pb_oe_o, 'h0F);

        // R11: mixed random traffic compared every cycle
        for (int i = 0; i < 400; i++) begin
            as_i        = ($urandom % 3) == 0;
            ad_i        = $urandom;
            ahi_i       = $urandom;
            ce_i        = ($urandom % 4) != 0;
            cfg_wr_i    = ($urandom % 8) == 0;
            cfg_sel_i   = $urandom;
            cfg_wdata_i = $urandom;
            rst_pin_i   = $urandom;
            pb_gpio_i   = $urandom;
            pb_dir_i    = $urandom;
            tick();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule